// File: doc/BRIEF.md
# Byte-Lane ROM Checksum Verifier

This block reads a 32-bit wide ROM from its first longword up to a byte count given at start time. It then reports whether the contents agree with checksums stored in the ROM itself. It fetches one longword per clock through a read port with a fixed latency of one cycle. When the scan has finished, it raises a done flag and presents a failure code, and both stay valid until the next start.

The block has two ways of checking. In lane mode it keeps four independent 32-bit sums, one for each byte position within the longword. It compares them with four reference sums held in a fixed hole in the ROM header, and the hole itself is left out of the sums. In whole mode it adds up the 16-bit halfwords and compares the total with a reference longword at address zero. Each mode reports failures in its own encoding, so a boot sequencer can read the result directly.

Top module: `rom_cksum_check`

## Requirements
- R1: After reset, `done` is 0, `fail_code` is 0 and `rom_addr` is 0.
- R2: A `start` pulse sampled while idle begins a scan at longword index 0. One longword address is issued per cycle, each one higher than the last. `done` rises on the (N+2)th rising edge after the edge that sampled `start`, where N = `rom_bytes`/4.
- R3: In lane mode (`whole_mode`=0), summing begins at byte address 4. Bits 31:24 of each longword go into lane 0, bits 23:16 into lane 1, bits 15:8 into lane 2 and bits 7:0 into lane 3. Each byte is zero-extended and added into a 32-bit sum.
- R4: In lane mode, longword indices 12 to 15 (byte offsets 0x30 to 0x3F) are kept out of the lane sums. Index 12+i holds the reference sum for lane i.
- R5: In lane mode, bit i of `fail_code` is 1 exactly when the sum for lane i differs from its reference. Bits 15:4 are 0.
- R6: In whole mode (`whole_mode`=1), the longword at index 0 is the reference. Every zero-extended halfword (bits 31:16 and bits 15:0) of indices 1 to N-1 is added into one 32-bit sum.
- R7: In whole mode, `fail_code` is 16'hFFFF when the sum differs from the reference and 0 when it matches.
- R8: A `start` pulse during a scan is ignored. The mode and size latched at the first start govern the whole scan and its result.
- R9: `done` and `fail_code` hold steady until the next accepted `start`, which clears `done`.
- R10: The scan stops at `rom_bytes`. `rom_addr` never exceeds N-1 during a scan, and words beyond the size do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a scan when idle |
| whole_mode | input | 1 | 1 selects the halfword sum, 0 selects the per-lane sums |
| rom_bytes | input | AW+1 | ROM size in bytes; a multiple of 4 and greater than 0x40 |
| rom_addr | output | AW-2 | Longword index presented to the ROM |
| rom_data | input | 32 | Longword returned one cycle after `rom_addr` |
| done | output | 1 | Scan finished; result valid |
| fail_code | output | 16 | Failure code in the encoding of the selected mode |

## Verification
The hardest conditions to reach are a result that depends on a single lane disagreeing, and a scan whose size ends far below the memory. Both must be shown while the header hole is excluded and the words past the end hold non-zero junk. The stimulus fills the whole ROM model with pseudo-random data and writes correct references computed by the bench. It then flips single bits in chosen reference words or data words to force each failing lane pattern. A second start pulse with a different mode and size is injected in the middle of one long scan, to show that it has no effect on the result.

// File: rtl/rom_cksum_check.sv
timeunit 1ns; timeprecision 1ps;

module rom_cksum_check #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          whole_mode,
  input  logic [AW:0]   rom_bytes,
  output logic [AW-3:0] rom_addr,
  input  logic [31:0]   rom_data,
  output logic          done,
  output logic [15:0]   fail_code
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] HOLE_LO = IW'(12);
  localparam logic [IW-1:0] HOLE_HI = IW'(15);

  logic          busy, issuing, rd_valid, fin, mode_q;
  logic [IW-1:0] iss_idx, rd_idx;
  logic [IW:0]   last_q;
  logic [31:0]   lane_acc [4];
  logic [31:0]   lane_ref [4];
  logic [31:0]   whole_acc, whole_ref;
  logic [3:0]    lane_miss;

  wire [IW:0] last_w   = rom_bytes[AW:2] - {{IW{1'b0}}, 1'b1};
  wire        iss_last = {1'b0, iss_idx} == last_w_q();
  wire        rd_last  = {1'b0, rd_idx} == last_q;
  wire        in_hole  = (rd_idx >= HOLE_LO) && (rd_idx <= HOLE_HI);

  function automatic logic [IW:0] last_w_q();
    return last_q;
  endfunction

  assign rom_addr = iss_idx;

  always_comb
    for (int i = 0; i < 4; i++) lane_miss[i] = lane_acc[i] != lane_ref[i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; issuing <= 1'b0; rd_valid <= 1'b0; fin <= 1'b0;
      mode_q <= 1'b0; iss_idx <= '0; rd_idx <= '0; last_q <= '0;
      whole_acc <= '0; whole_ref <= '0; done <= 1'b0; fail_code <= '0;
      for (int i = 0; i < 4; i++) begin
        lane_acc[i] <= '0;
        lane_ref[i] <= '0;
      end
    end else begin
      fin <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; issuing <= 1'b1; rd_valid <= 1'b0;
        iss_idx <= '0; mode_q <= whole_mode; last_q <= last_w;
        done <= 1'b0; fail_code <= '0; whole_acc <= '0; whole_ref <= '0;
        for (int i = 0; i < 4; i++) begin
          lane_acc[i] <= '0;
          lane_ref[i] <= '0;
        end
      end else begin
        rd_valid <= issuing;
        rd_idx   <= iss_idx;
        if (issuing) begin
          if (iss_last) issuing <= 1'b0;
          else          iss_idx <= iss_idx + 1'b1;
        end
        if (rd_valid) begin
          if (rd_last) fin <= 1'b1;
          if (mode_q) begin
            if (rd_idx == '0) whole_ref <= rom_data;
            else whole_acc <= whole_acc + {16'h0, rom_data[31:16]} + {16'h0, rom_data[15:0]};
          end else if (in_hole) begin
            lane_ref[rd_idx[1:0]] <= rom_data;
          end else if (rd_idx != '0) begin
            for (int i = 0; i < 4; i++)
              lane_acc[i] <= lane_acc[i] + {24'h0, rom_data[31-8*i -: 8]};
          end
        end
        if (fin) begin
          done <= 1'b1;
          busy <= 1'b0;
          fail_code <= mode_q ? {16{whole_acc != whole_ref}} : {12'h0, lane_miss};
        end
      end
    end
  end

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing && !iss_last && !(start && !busy)) |=> rom_addr == IW'($past(rom_addr) + 1'b1));

  p_lane_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> fail_code[15:4] == 12'h0);

  p_whole_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |-> (fail_code == 16'h0 || fail_code == 16'hFFFF));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (mode_q == $past(mode_q) && last_q == $past(last_q)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail_code)));

  p_addr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> {1'b0, rom_addr} <= last_q);

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/rom_cksum_check_bench.sv
timeunit 1ns; timeprecision 1ps;

module rom_cksum_check_bench;
  localparam int AW = 12;
  localparam int NW = 1 << (AW - 2);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, start, whole_mode;
  logic [AW:0]   rom_bytes;
  logic [AW-3:0] rom_addr;
  logic [31:0]   rom_data;
  logic          done;
  logic [15:0]   fail_code;
  logic [31:0]   mem [0:NW-1];
  logic [31:0]   lcg = 32'h1234_5678;
  int vecs = 0, errs = 0;

  rom_cksum_check #(.AW(AW)) u_rom_cksum_check (
    .clk(clk), .rst_n(rst_n), .start(start), .whole_mode(whole_mode),
    .rom_bytes(rom_bytes), .rom_addr(rom_addr), .rom_data(rom_data),
    .done(done), .fail_code(fail_code)
  );

  always_ff @(posedge clk) rom_data <= mem[rom_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_junk();
    for (int i = 0; i < NW; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      mem[i] = lcg ^ {lcg[15:0], lcg[31:16]};
    end
  endtask

  task automatic lane_sums(input int nbytes, output logic [31:0] s [4]);
    for (int i = 0; i < 4; i++) s[i] = 0;
    for (int w = 1; w < nbytes / 4; w++)
      if (w < 12 || w > 15)
        for (int i = 0; i < 4; i++) s[i] += 32'((mem[w] >> (24 - 8 * i)) & 32'hFF);
  endtask

  function automatic logic [31:0] whole_sum(input int nbytes);
    logic [31:0] s = 0;
    for (int w = 1; w < nbytes / 4; w++) s += {16'h0, mem[w][31:16]} + {16'h0, mem[w][15:0]};
    return s;
  endfunction

  task automatic set_lane_refs(input int nbytes);
    logic [31:0] s [4];
    lane_sums(nbytes, s);
    for (int i = 0; i < 4; i++) mem[12 + i] = s[i];
  endtask

  task automatic expect_code(input bit wm, input int nbytes, output logic [15:0] e);
    logic [31:0] s [4];
    if (wm) e = (whole_sum(nbytes) != mem[0]) ? 16'hFFFF : 16'h0;
    else begin
      lane_sums(nbytes, s);
      e = 0;
      for (int i = 0; i < 4; i++) e[i] = (s[i] != mem[12 + i]);
    end
  endtask

  task automatic run(input bit wm, input int nbytes, input string req, input bit poke);
    logic [15:0] e;
    int n = nbytes / 4;
    expect_code(wm, nbytes, e);
    @(negedge clk);
    whole_mode = wm; rom_bytes = (AW+1)'(nbytes); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n + 4; k++) begin
      if (poke && k == 3) begin start = 1'b1; whole_mode = ~wm; rom_bytes = 'h44; end
      if (poke && k == 4) begin start = 1'b0; whole_mode = wm; end
      @(posedge clk);
      @(negedge clk);
      chk({req, " R2 done timing"}, done, (k >= n + 2));
      chk({req, " R10 addr bound"}, (int'(rom_addr) <= n - 1), 1);
      if (k >= n + 2) chk({req, " R9 result held"}, fail_code, e);
    end
  endtask

  initial begin
    #4000000;
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; whole_mode = 1'b0; rom_bytes = '0;
    fill_junk();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 fail_code", fail_code, 0);
    chk("R1 rom_addr", rom_addr, 0);
    rst_n = 1'b1;

    set_lane_refs('h44);
    run(1'b0, 'h44, "R3 R4 lane min size", 1'b0);
    chk("R5 lane good", fail_code, 16'h0);

    set_lane_refs('h400);
    run(1'b0, 'h400, "R3 lane 0x400", 1'b0);
    chk("R4 lane good hole", fail_code, 16'h0);

    mem[14] ^= 32'h1;
    run(1'b0, 'h400, "R5 lane2 bad", 1'b0);
    chk("R5 lane2 code", fail_code, 16'h0004);

    set_lane_refs('h400);
    mem[12] ^= 32'h100; mem[15] ^= 32'h8000_0000;
    run(1'b0, 'h400, "R5 lanes0,3 bad", 1'b0);
    chk("R5 lanes 0 and 3 code", fail_code, 16'h0009);

    set_lane_refs('h400);
    mem[20] = mem[20] + 32'h0100_0000;
    run(1'b0, 'h400, "R3 lane0 data bad", 1'b0);
    chk("R3 msb byte in lane 0", fail_code, 16'h0001);

    mem[0] = whole_sum('h400);
    run(1'b1, 'h400, "R6 whole good", 1'b0);
    chk("R6 whole match", fail_code, 16'h0);

    mem[5] ^= 32'h0001_0000;
    run(1'b1, 'h400, "R7 whole bad", 1'b0);
    chk("R7 whole mismatch", fail_code, 16'hFFFF);

    mem[0] = whole_sum('h1000);
    run(1'b1, 'h1000, "R8 busy start", 1'b1);
    chk("R8 start ignored", fail_code, 16'h0);

    set_lane_refs('h100);
    run(1'b0, 'h100, "R10 short scan", 1'b0);
    chk("R10 junk beyond size", fail_code, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule